// File: doc/BRIEF.md
# Charge Duty-Factor and Status Pattern Generator

This block turns the charger's current phase into two outputs. The first is `charge_enable`, which qualifies an external hysteretic current regulator so that charge current flows only for a phase-dependent fraction of time. The second is `status`, a waveform that drives an indicator LED or a host input. Time is split into base slots, each one `base_tick` long (nominally 0.96 s). A slot counter gives the duty factor: 31 slots out of 32 in fast charge, 1 in 4 in precharge and top-off, and 1 in 64 in maintenance. The single disabled slot of every 32 in fast charge lines up with the periodic cell-test window.

The sequencer upstream supplies a 3-bit phase code and a flag that is high while a cell test is running. A faster `sys_tick` drives two blink dividers. These give a slow blink (1 Hz with default parameters) during precharge and a fast blink (4 Hz) in fault. Each blink has a 50 % duty. Any change of the phase code restarts the slot count and the blink phase. In every phase that allows charge, the enable is therefore granted at once on entry, and a blink always begins with its high half.

Top module: `chg_duty_status`

## Requirements
- R1: While `rst_n` is low, `charge_enable` and `status` are 0.
- R2: Phase codes 0 (no cell), 5 (fault), 6 (suspend) and 7 (reserved) hold `charge_enable` at 0 from the first clock edge that samples the code. It is never 1 in that cycle or later.
- R3: When `cell_test_active` is 1 at an edge, `charge_enable` is 0 after that edge. The flag does not affect `status`.
- R4: In fast charge (code 2), base slot s is enabled unless s mod 32 equals 31. That gives 31 enabled slots of every 32.
- R5: In precharge (code 1) and top-off (code 3), base slot s is enabled only when s mod 4 equals 0.
- R6: In maintenance (code 4), base slot s is enabled only when s mod 64 equals 0.
- R7: A change of phase code resets the slot number to 0. Slot 0 is enabled in codes 1 to 4, so `charge_enable` is 1 from the edge that samples the new code (unless R3 applies). Each later `base_tick` advances the slot by one.
- R8: `status` is 1 in codes 2 and 3. It is 0 in codes 0, 4, 6 and 7.
- R9: In precharge, `status` is 1 for SLOW_HALF `sys_tick` pulses, then 0 for SLOW_HALF pulses, and repeats. It changes only on an edge that samples a `sys_tick`.
- R10: In fault, `status` blinks the same way with FAST_HALF pulses per half period.
- R11: A change of phase code restarts the blink with `status` 1, from the edge that samples the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | Single-cycle pulse that clocks the blink dividers |
| base_tick | input | 1 | Single-cycle pulse marking the end of a base slot |
| state_code | input | 3 | Charge phase code: 0 no cell, 1 precharge, 2 fast, 3 top-off, 4 maintenance, 5 fault, 6 suspend, 7 reserved |
| cell_test_active | input | 1 | High while a cell test runs; blocks charge |
| charge_enable | output | 1 | Registered charge qualification for the current regulator |
| status | output | 1 | Indicator waveform |

## Verification
The bench builds the block with SLOW_HALF = 6 and FAST_HALF = 2. Several full blink periods in both precharge and fault then fit in a few dozen cycles, and the bench can check every transition. The slot periods keep their defaults of 32, 4 and 64. The bench pulses `base_tick` directly, so it can walk through the whole 64-slot maintenance cycle and past the disabled slot 31 of fast charge. It also switches phase in the middle of a count, to show that the slot number and the blink restart.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        PH_NOCELL  = 3'd0,
        PH_PRE     = 3'd1,
        PH_FAST    = 3'd2,
        PH_TOPOFF  = 3'd3,
        PH_MAINT   = 3'd4,
        PH_FAULT   = 3'd5,
        PH_SUSPEND = 3'd6,
        PH_RSVD    = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        DM_OFF   = 2'd0,
        DM_FAST  = 2'd1,
        DM_QUART = 2'd2,
        DM_TRICK = 2'd3
    } duty_mode_e;

    function automatic duty_mode_e duty_of(input logic [2:0] code);
        case (code)
            PH_FAST:         duty_of = DM_FAST;
            PH_PRE,
            PH_TOPOFF:       duty_of = DM_QUART;
            PH_MAINT:        duty_of = DM_TRICK;
            default:         duty_of = DM_OFF;
        endcase
    endfunction

endpackage

// File: rtl/chg_slot_gate.sv
module chg_slot_gate
    import chg_pkg::*;
#(
    parameter int FAST_PERIOD  = 32,
    parameter int QUART_PERIOD = 4,
    parameter int TRICK_PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       base_tick,
    input  duty_mode_e mode,
    input  logic       hold,
    output logic       en_q
);
    localparam int MAX_A   = (FAST_PERIOD > QUART_PERIOD) ? FAST_PERIOD : QUART_PERIOD;
    localparam int MAX_P   = (MAX_A > TRICK_PERIOD) ? MAX_A : TRICK_PERIOD;
    localparam int SLOT_W  = (MAX_P > 2) ? $clog2(MAX_P) : 1;
    localparam logic [SLOT_W-1:0] FAST_MASK  = SLOT_W'(FAST_PERIOD - 1);
    localparam logic [SLOT_W-1:0] QUART_MASK = SLOT_W'(QUART_PERIOD - 1);
    localparam logic [SLOT_W-1:0] TRICK_MASK = SLOT_W'(TRICK_PERIOD - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              en;
    } gate_t;

    gate_t r_d, r_q;
    logic  window;

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.slot = '0;
        end else if (base_tick) begin
            r_d.slot = r_q.slot + 1'b1;
        end
        case (mode)
            DM_FAST:  window = ((r_d.slot & FAST_MASK) != FAST_MASK);
            DM_QUART: window = ((r_d.slot & QUART_MASK) == '0);
            DM_TRICK: window = ((r_d.slot & TRICK_MASK) == '0);
            default:  window = 1'b0;
        endcase
        r_d.en = window && !hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_q = r_q.en;

    assert_off_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DM_OFF) |=> !en_q);
    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !en_q);
    assert_slot_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick && !restart) |=> $stable(r_q.slot));
    assert_entry_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && mode != DM_OFF && !hold) |=> en_q);

endmodule

// File: rtl/chg_blinker.sv
module chg_blinker #(
    parameter int SLOW_HALF = 500,
    parameter int FAST_HALF = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sys_tick,
    input  logic fast_rate,
    output logic phase_q
);
    localparam int MAX_H  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int HALF_W = (MAX_H > 1) ? $clog2(MAX_H + 1) : 1;
    localparam logic [HALF_W-1:0] SLOW_LAST = HALF_W'(SLOW_HALF - 1);
    localparam logic [HALF_W-1:0] FAST_LAST = HALF_W'(FAST_HALF - 1);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              ph;
    } blink_t;

    blink_t            r_d, r_q;
    logic [HALF_W-1:0] last;

    always_comb begin
        r_d  = r_q;
        last = fast_rate ? FAST_LAST : SLOW_LAST;
        if (restart) begin
            r_d.cnt = '0;
            r_d.ph  = 1'b1;
        end else if (sys_tick) begin
            if (r_q.cnt >= last) begin
                r_d.cnt = '0;
                r_d.ph  = ~r_q.ph;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_q = r_q.ph;

    assert_blink_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_tick && !restart) |=> $stable(phase_q));
    assert_blink_high_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> phase_q);

endmodule

// File: rtl/chg_duty_status.sv
module chg_duty_status
    import chg_pkg::*;
#(
    parameter int FAST_PERIOD  = 32,
    parameter int QUART_PERIOD = 4,
    parameter int TRICK_PERIOD = 64,
    parameter int SLOW_HALF    = 500,
    parameter int FAST_HALF    = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_tick,
    input  logic       base_tick,
    input  logic [2:0] state_code,
    input  logic       cell_test_active,
    output logic       charge_enable,
    output logic       status
);
    typedef struct packed {
        logic [2:0] code;
    } top_t;

    top_t       r_d, r_q;
    logic       restart;
    duty_mode_e mode;
    logic       blink;

    always_comb begin
        r_d      = r_q;
        r_d.code = state_code;
        restart  = (state_code != r_q.code);
        mode     = duty_of(state_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    chg_slot_gate #(
        .FAST_PERIOD (FAST_PERIOD),
        .QUART_PERIOD(QUART_PERIOD),
        .TRICK_PERIOD(TRICK_PERIOD)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .base_tick(base_tick),
        .mode     (mode),
        .hold     (cell_test_active),
        .en_q     (charge_enable)
    );

    chg_blinker #(
        .SLOW_HALF(SLOW_HALF),
        .FAST_HALF(FAST_HALF)
    ) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sys_tick (sys_tick),
        .fast_rate(state_code == PH_FAULT),
        .phase_q  (blink)
    );

    always_comb begin
        case (r_q.code)
            PH_FAST,
            PH_TOPOFF: status = rst_n;
            PH_PRE,
            PH_FAULT:  status = blink && rst_n;
            default:   status = 1'b0;
        endcase
    end

    assert_status_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == PH_FAST || state_code == PH_TOPOFF) |=> status);
    assert_status_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == PH_MAINT || state_code == PH_SUSPEND ||
         state_code == PH_NOCELL || state_code == PH_RSVD) |=> !status);
    assert_no_charge_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == PH_FAULT || state_code == PH_SUSPEND ||
         state_code == PH_NOCELL || state_code == PH_RSVD) |=> !charge_enable);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!charge_enable && !status));

endmodule

// File: tb/chg_duty_status_tb.sv
module chg_duty_status_tb;
    localparam int SLOW_H = 6;
    localparam int FAST_H = 2;
    localparam logic [2:0] C_NOCELL = 3'd0, C_PRE = 3'd1, C_FAST = 3'd2, C_TOP = 3'd3,
                           C_MAINT = 3'd4, C_FAULT = 3'd5, C_SUSP = 3'd6, C_RSVD = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_tick = 1'b0;
    logic       base_tick = 1'b0;
    logic [2:0] state_code = 3'd0;
    logic       cell_test_active = 1'b0;
    logic       charge_enable, status;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    chg_duty_status #(.SLOW_HALF(SLOW_H), .FAST_HALF(FAST_H)) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .base_tick(base_tick),
        .state_code(state_code), .cell_test_active(cell_test_active),
        .charge_enable(charge_enable), .status(status));

    task automatic chk(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // one clock: pulses held for exactly one edge, called and returning at negedge
    task automatic cyc(input logic bt, input logic st);
        base_tick = bt;
        sys_tick  = st;
        @(negedge clk);
        base_tick = 1'b0;
        sys_tick  = 1'b0;
    endtask

    task automatic t_reset();
        chk(charge_enable, 1'b0, "R1 enable in reset");
        chk(status, 1'b0, "R1 status in reset");
        state_code = C_FAST;
        cyc(1'b1, 1'b1);
        chk(charge_enable, 1'b0, "R1 enable held in reset");
        chk(status, 1'b0, "R1 status held in reset");
        state_code = C_NOCELL;
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b0, "R2 no-cell enable");
        chk(status, 1'b0, "R8 no-cell status");
    endtask

    task automatic t_off_states();
        logic [2:0] codes [4] = '{C_NOCELL, C_FAULT, C_SUSP, C_RSVD};
        for (int i = 0; i < 4; i++) begin
            state_code = C_FAST;
            cyc(1'b0, 1'b0);
            state_code = codes[i];
            cyc(1'b0, 1'b0);
            chk(charge_enable, 1'b0, "R2 off on entry");
            for (int k = 0; k < 5; k++) begin
                cyc(1'b1, 1'b1);
                chk(charge_enable, 1'b0, "R2 off while ticking");
            end
        end
    endtask

    task automatic t_fast();
        state_code = C_NOCELL;
        cyc(1'b0, 1'b0);
        state_code = C_FAST;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b1, "R7 fast entry slot 0");
        chk(status, 1'b1, "R8 fast status");
        for (int k = 1; k <= 34; k++) begin
            cyc(1'b1, 1'b0);
            chk(charge_enable, (k % 32) != 31, "R4 fast slot");
            chk(status, 1'b1, "R8 fast status steady");
        end
        cyc(1'b0, 1'b1);
        chk(status, 1'b1, "R8 fast ignores sys_tick");
    endtask

    task automatic t_cell_test();
        // still in fast charge, slot 34 (enabled)
        cell_test_active = 1'b1;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b0, "R3 cell test blocks");
        chk(status, 1'b1, "R3 status unchanged in cell test");
        cyc(1'b1, 1'b0);
        chk(charge_enable, 1'b0, "R3 cell test blocks across slot");
        cell_test_active = 1'b0;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b1, "R3 release restores slot 35");
    endtask

    task automatic t_quarter(input logic [2:0] code, input string req);
        state_code = code;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b1, "R7 entry grants slot 0");
        for (int k = 1; k <= 9; k++) begin
            cyc(1'b1, 1'b0);
            chk(charge_enable, (k % 4) == 0, req);
            cyc(1'b0, 1'b0);
            chk(charge_enable, (k % 4) == 0, req);
        end
    endtask

    task automatic t_top();
        t_quarter(C_TOP, "R5 top-off slot");
        chk(status, 1'b1, "R8 top-off status");
    endtask

    task automatic t_maint();
        state_code = C_MAINT;
        cyc(1'b0, 1'b0);
        chk(charge_enable, 1'b1, "R7 maint entry");
        chk(status, 1'b0, "R8 maint status");
        for (int k = 1; k <= 66; k++) begin
            cyc(1'b1, 1'b1);
            chk(charge_enable, (k % 64) == 0, "R6 maint slot");
        end
        chk(status, 1'b0, "R8 maint status after ticks");
        // slot 66 now; a switch restarts the count
        state_code = C_TOP;
        cyc(1'b1, 1'b0);
        chk(charge_enable, 1'b1, "R7 restart beats base_tick");
        cyc(1'b1, 1'b0);
        chk(charge_enable, 1'b0, "R7 count from zero after switch");
    endtask

    task automatic t_blink(input logic [2:0] code, input int half, input string req);
        state_code = code;
        cyc(1'b0, 1'b0);
        chk(status, 1'b1, "R11 blink starts high");
        for (int k = 1; k <= 4 * half; k++) begin
            cyc(1'b0, 1'b1);
            chk(status, ((k / half) % 2) == 0, req);
            cyc(1'b1, 1'b0);
            chk(status, ((k / half) % 2) == 0, req);
        end
    endtask

    task automatic t_blink_restart();
        state_code = C_PRE;
        cyc(1'b0, 1'b0);
        for (int k = 0; k < SLOW_H; k++) cyc(1'b0, 1'b1);
        chk(status, 1'b0, "R9 precharge low half");
        state_code = C_FAULT;
        cyc(1'b0, 1'b0);
        chk(status, 1'b1, "R11 fault restarts high");
        chk(charge_enable, 1'b0, "R2 fault enable");
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        chk(status, 1'b0, "R10 fault low after half");
        state_code = C_SUSP;
        cyc(1'b0, 1'b1);
        chk(status, 1'b0, "R8 suspend status");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_off_states();
        t_fast();
        t_cell_test();
        t_quarter(C_PRE, "R5 precharge slot");
        t_top();
        t_maint();
        t_blink(C_PRE, SLOW_H, "R9 precharge blink");
        t_blink(C_FAULT, FAST_H, "R10 fault blink");
        t_blink_restart();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule